// File: doc/BRIEF.md
# Double-Buffered Nibble-Addressable DAC Code Register

This block sits between a processor data bus and a 12-bit digital-to-analog converter core. It collects the converter code through three independently strobed 4-bit holding slices: low, middle and high. A word can therefore be written from a 4-, 8-, 12- or 16-bit bus in one or more accesses. A separate transfer strobe copies the whole holding stage into the output register in a single step. The converter never sees a half-written code.

Every strobe is active low and is qualified by an active-low chip select. The strobes are sampled on the rising clock edge. Any mix of strobes may be active in the same cycle. When a slice strobe and the transfer strobe are both active, the new slice data reaches the output in that same update. With all strobes low the path acts as transparent, and the output follows the bus one clock later. A mode input inverts the data MSB before it is stored, which lets two's-complement codes drive a converter that expects offset binary. A one-cycle update pulse marks every change of the output code.

Top module: `dac_word_stager`

## Requirements
- R1: While `rst_n` is low at a clock edge, both stages clear to 000h and `code_upd` clears to 0. With parameter `MID_RESET` = 1, both stages clear instead to 800h.
- R2: While `cs_n` is high, no strobe has any effect. A later transfer shows the holding stage unchanged.
- R3: With `cs_n` low and all four `strobe_n` bits high, nothing changes.
- R4: With `cs_n` low, `strobe_n[0]` loads holding bits 3:0, `strobe_n[1]` loads bits 7:4 and `strobe_n[2]` loads bits 11:8, each from the same bits of the formatted data. Slices whose strobe is high keep their value.
- R5: With `cs_n` low and `strobe_n[3]` low, `code` takes the whole holding stage one clock later. Without this transfer, `code` holds its value.
- R6: When a slice strobe and the transfer strobe are active in the same cycle, `code` shows the new slice data after that single edge.
- R7: With `cs_n` low and `strobe_n` = 0000, `code` equals the formatted data of the previous cycle, every cycle.
- R8: With `twos_mode` = 1, data bit 11 is inverted before it is stored and bits 10:0 pass unchanged. With `twos_mode` = 0, the data is stored as given.
- R9: `code_upd` is high for exactly the one cycle after each edge at which `code` changes value. A transfer that leaves `code` unchanged gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select qualifying all strobes |
| strobe_n | input | 4 | Active-low strobes: bits 2:0 select holding slices high/mid/low, bit 3 selects transfer |
| din | input | 12 | Bus data, positive-true binary |
| twos_mode | input | 1 | 1 = invert data MSB on entry (two's-complement input) |
| code | output | 12 | Converter code from the output stage |
| code_upd | output | 1 | One-cycle pulse after each change of `code` |

## Verification
Three access patterns are applied. The first writes the slices one at a time and then transfers them; it separates each slice's strobe and shows that the output stays put until the transfer. The second is the left-justified two-access byte pattern, in which the low slice is loaded first and the upper eight bits are then loaded together with the transfer; it shows whether the update is truly flow-through. The third holds all strobes low, including the carry codes 7FFh and 800h; it shows transparency and, with the mode input set, that only the MSB is inverted. Writes with the chip select high, or with no strobe active, followed by a transfer, show that the holding stage was left untouched.

// File: rtl/dws_pkg.sv
// Package: shared coding type and reset-word helper for the DAC code stager.
// Assumes code widths of at most 32 bits.
package dws_pkg;

    typedef enum logic {
        CODING_BINARY = 1'b0,
        CODING_TWOS   = 1'b1
    } dws_coding_e;

    // Reset word: zero, or the mid-scale code (MSB set) when mid is requested.
    function automatic logic [31:0] dws_reset_word(input int unsigned width, input bit mid);
        logic [31:0] w;
        w = '0;
        if (mid) w[width-1] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/dws_input_fmt.sv
// Module: dws_input_fmt
// Formats bus data before it is stored: optionally inverts the MSB so that
// two's-complement input becomes offset binary. Purely combinational.
module dws_input_fmt
    import dws_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] din,
    input  logic         twos_mode,
    output logic [W-1:0] dout
);

    dws_coding_e coding;

    // Purpose: decode the coding mode and flip only the MSB in two's mode.
    always_comb begin
        coding = dws_coding_e'(twos_mode);
        dout   = din;
        if (coding == CODING_TWOS) dout[W-1] = ~din[W-1];
    end

endmodule

// File: rtl/dws_hold_rank.sv
// Module: dws_hold_rank
// First stage: NIB_N independently enabled slices of NIB_W bits. Exposes the
// next-state word so the output stage can copy fresh data in the same edge.
// Assumes enables are already qualified by chip select and active high.
module dws_hold_rank
    import dws_pkg::*;
#(
    parameter int unsigned NIB_W     = 4,
    parameter int unsigned NIB_N     = 3,
    parameter bit          MID_RESET = 1'b0,
    localparam int unsigned W        = NIB_W * NIB_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_N-1:0] en,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     nxt
);

    localparam logic [W-1:0] RST_WORD = W'(dws_reset_word(W, MID_RESET));

    logic [W-1:0] hold_q;

    for (genvar g = 0; g < NIB_N; g++) begin : g_slice
        // Purpose: choose new data or keep the slice for the next state.
        always_comb begin
            nxt[g*NIB_W +: NIB_W] = en[g] ? din[g*NIB_W +: NIB_W] : hold_q[g*NIB_W +: NIB_W];
        end

        // Purpose: register one slice with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) hold_q[g*NIB_W +: NIB_W] <= RST_WORD[g*NIB_W +: NIB_W];
            else        hold_q[g*NIB_W +: NIB_W] <= nxt[g*NIB_W +: NIB_W];
        end

        AST_SLICE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !en[g] |=> $stable(hold_q[g*NIB_W +: NIB_W])); // R4
    end

endmodule

// File: rtl/dws_out_rank.sv
// Module: dws_out_rank
// Second stage: copies the whole first-stage next-state word on transfer and
// pulses an update flag when the stored code changes value.
// Assumes xfer is already qualified by chip select and active high.
module dws_out_rank
    import dws_pkg::*;
#(
    parameter int unsigned W         = 12,
    parameter bit          MID_RESET = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xfer,
    input  logic [W-1:0] nxt_word,
    output logic [W-1:0] code,
    output logic         upd
);

    localparam logic [W-1:0] RST_WORD = W'(dws_reset_word(W, MID_RESET));

    // Purpose: load the output code and flag a change of value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= RST_WORD;
            upd  <= 1'b0;
        end else begin
            if (xfer) code <= nxt_word;
            upd <= xfer && (nxt_word != code);
        end
    end

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(code)); // R5
    AST_UPD_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (code != $past(code))); // R9

endmodule

// File: rtl/dac_word_stager.sv
// Module: dac_word_stager
// Top: double-buffered, slice-addressable code register for a DAC core.
// Assumes strobes and chip select are synchronous to clk, sampled each edge.
module dac_word_stager
    import dws_pkg::*;
#(
    parameter int unsigned NIB_W     = 4,
    parameter int unsigned NIB_N     = 3,
    parameter bit          MID_RESET = 1'b0,
    localparam int unsigned W        = NIB_W * NIB_N,
    localparam int unsigned SN       = NIB_N + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic [SN-1:0] strobe_n,
    input  logic [W-1:0]  din,
    input  logic          twos_mode,
    output logic [W-1:0]  code,
    output logic          code_upd
);

    logic [W-1:0]     fmt_data;
    logic [W-1:0]     hold_nxt;
    logic [NIB_N-1:0] slice_en;
    logic             xfer_en;

    // Purpose: qualify every strobe with chip select.
    always_comb begin
        slice_en = ~strobe_n[NIB_N-1:0] & {NIB_N{~cs_n}};
        xfer_en  = ~strobe_n[NIB_N] & ~cs_n;
    end

    dws_input_fmt #(.W(W)) u_fmt (
        .din       (din),
        .twos_mode (twos_mode),
        .dout      (fmt_data)
    );

    dws_hold_rank #(.NIB_W(NIB_W), .NIB_N(NIB_N), .MID_RESET(MID_RESET)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (slice_en),
        .din   (fmt_data),
        .nxt   (hold_nxt)
    );

    dws_out_rank #(.W(W), .MID_RESET(MID_RESET)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer     (xfer_en),
        .nxt_word (hold_nxt),
        .code     (code),
        .upd      (code_upd)
    );

    AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(code)); // R2
    AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (&strobe_n) |=> $stable(code) && !code_upd); // R3
    AST_FLOW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !strobe_n[0] && !strobe_n[NIB_N]) |=> code[NIB_W-1:0] == $past(din[NIB_W-1:0])); // R6
    AST_TRANSPARENT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && strobe_n == '0) |=> code[W-2:0] == $past(din[W-2:0])); // R7
    AST_MSB_CODING: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && strobe_n == '0) |=> code[W-1] == ($past(din[W-1]) ^ $past(twos_mode))); // R8

endmodule

// File: tb/dac_word_stager_bench.sv
module dac_word_stager_bench;

    typedef struct {
        logic [11:0] code;
        logic        upd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n;
    logic [3:0]  strobe_n;
    logic [11:0] din;
    logic        twos_mode;
    logic [11:0] code, code_mid;
    logic        code_upd, code_upd_mid;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    logic [11:0] m_hold = '0;
    logic [11:0] m_code = '0;

    always #10 clk = ~clk;

    dac_word_stager u_dac_word_stager (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strobe_n(strobe_n),
        .din(din), .twos_mode(twos_mode), .code(code), .code_upd(code_upd)
    );

    dac_word_stager #(.MID_RESET(1'b1)) u_dac_word_stager_mid (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strobe_n(strobe_n),
        .din(din), .twos_mode(twos_mode), .code(code_mid), .code_upd(code_upd_mid)
    );

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic cyc(input logic rs, input logic cs, input logic [3:0] sn,
                       input logic [11:0] d, input logic tm, input string tag);
        logic [11:0] dd, n_hold, n_code;
        logic        n_upd;
        exp_t        e;
        @(negedge clk);
        rst_n = rs; cs_n = cs; strobe_n = sn; din = d; twos_mode = tm;
        dd = tm ? (d ^ 12'h800) : d;
        n_hold = m_hold;
        if (!cs) for (int i = 0; i < 3; i++) if (!sn[i]) n_hold[4*i +: 4] = dd[4*i +: 4];
        n_code = (!cs && !sn[3]) ? n_hold : m_code;
        n_upd  = (n_code != m_code);
        if (!rs) begin n_hold = '0; n_code = '0; n_upd = 1'b0; end
        m_hold = n_hold; m_code = n_code;
        e.code = n_code; e.upd = n_upd; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare the design's result after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (code !== e.code || code_upd !== e.upd) begin
                    errors++;
                    $display("FAIL %s code=%h exp=%h upd=%b exp=%b", e.tag, code, e.code, code_upd, e.upd);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; strobe_n = 4'hF; din = '0; twos_mode = 1'b0;
        cyc(0, 1, 4'hF, 12'hFFF, 0, "R1 reset");
        cyc(0, 0, 4'h0, 12'hFFF, 0, "R1 reset overrides strobes");
        @(posedge clk); #6;
        checks++;
        if (code_mid !== 12'h800) begin
            errors++;
            $display("FAIL R1 mid reset code=%h exp=%h", code_mid, 12'h800);
        end
        cyc(1, 1, 4'hF, 12'h000, 0, "R1 idle after reset");
        // R4/R5: one slice at a time, output held until transfer
        cyc(1, 0, 4'b1110, 12'hABC, 0, "R4 low slice, R5 no transfer");
        cyc(1, 0, 4'b1101, 12'h123, 0, "R4 mid slice");
        cyc(1, 0, 4'b1011, 12'h9FF, 0, "R4 high slice");
        cyc(1, 0, 4'b0111, 12'h000, 0, "R5 transfer 92C, R9 pulse");
        cyc(1, 1, 4'hF,    12'h000, 0, "R9 pulse one cycle");
        // R2: chip select high blocks everything
        cyc(1, 1, 4'b0000, 12'hFFF, 0, "R2 cs high");
        cyc(1, 0, 4'b0111, 12'h000, 0, "R2 hold intact, R9 no pulse");
        // R3: no strobe
        cyc(1, 0, 4'b1111, 12'h555, 0, "R3 no strobe");
        cyc(1, 0, 4'b0111, 12'h000, 0, "R3 hold intact");
        // R6: flow-through
        cyc(1, 0, 4'b0110, 12'h007, 0, "R6 low+transfer");
        cyc(1, 0, 4'b1110, 12'h00D, 0, "R6 left-justified first access");
        cyc(1, 0, 4'b0001, 12'hA50, 0, "R6 left-justified second access");
        // R7: transparent
        cyc(1, 0, 4'b0000, 12'h111, 0, "R7 transparent");
        cyc(1, 0, 4'b0000, 12'h7FF, 0, "R7 transparent 7FF");
        cyc(1, 0, 4'b0000, 12'h800, 0, "R7 transparent 800");
        cyc(1, 0, 4'b0000, 12'h800, 0, "R7 R9 same code no pulse");
        // R8: two's-complement input
        cyc(1, 0, 4'b0000, 12'h000, 1, "R8 twos 000");
        cyc(1, 0, 4'b0000, 12'h7FF, 1, "R8 twos 7FF");
        cyc(1, 0, 4'b0000, 12'h800, 1, "R8 twos 800");
        cyc(1, 0, 4'b1110, 12'hF0F, 1, "R8 low slice untouched by MSB flip");
        cyc(1, 0, 4'b1011, 12'hF00, 1, "R8 high slice inverted");
        cyc(1, 0, 4'b0111, 12'h000, 1, "R8 transfer");
        cyc(1, 0, 4'b0000, 12'hC3A, 0, "R8 binary mode");
        // R1: reset mid-run
        cyc(0, 1, 4'hF, 12'h000, 0, "R1 reset mid-run");
        cyc(1, 0, 4'b0111, 12'h000, 0, "R1 hold cleared");
        wait (sb_q.size() == 0);
        @(posedge clk); #7;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule